// File: doc/BRIEF.md
# Predicated Halfword Store Sequencer

This block turns one predicated vector store operation into a stream of 16-bit memory writes. It checks a 32-bit operation word, and it breaks out the register fields and the element-size code for the surrounding pipeline. Once an operation is accepted, the block scans the elements of the captured vector in ascending order. For each active element it issues one 2-byte write on a valid/ready port. The write carries the low halfword of that element.

The first address is the 64-bit base plus twice the index. The sum wraps modulo 2^64. The running address then steps by 2 for every element position, and it steps even when that element is skipped. The vector width is the parameter `VLEN`, and the element size is chosen per operation by the size code. Two encodings must raise an undefined-instruction fault: size code 00, and an index register field of all ones. A stack-pointer base with no active element raises an alignment-check request.

Top module: `halfword_pred_store`

## Requirements
- R1: The operation word is recognised when bits 31:25 = 1110010, bits 24:23 = 01 and bits 15:13 = 010. The block outputs the fields size = bits 22:21, index register = bits 20:16, predicate register = bits 12:10, base register = bits 9:5 and data register = bits 4:0. A word that is not recognised never starts an operation.
- R2: A recognised word with size code 00, or with index register field 11111, drives `undef` high, and `start` does not begin an operation.
- R3: The first write address is base + index × 2, computed modulo 2^64.
- R4: The running address grows by 2 for every element position scanned, whether or not that position is written.
- R5: The element width is 8 << size (01 = 16, 10 = 32, 11 = 64 bits). There are VLEN / width element positions, and they are scanned from element 0 upwards.
- R6: Each write carries bits [15:0] of its element, and `wr_bytes` is 2.
- R7: Element e is active when predicate bit e × width / 8 is set. An inactive element produces no write.
- R8: `sp_align_req` is high in the accepting cycle when the base register field is 11111 and no element is active. `sp_base` is high whenever that field is 11111.
- R9: `done` is high for exactly one cycle, in the cycle after the last position completes, and `busy` is low in that cycle. One operation takes (positions + stall cycles) cycles.
- R10: `start` while `busy` is high is ignored.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R12: After reset, `busy`, `done` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin the operation described by the inputs |
| instr | input | 32 | Operation word |
| vec_data | input | VLEN | Vector register value |
| pred | input | VLEN/8 | Governing predicate, one bit per vector byte |
| base | input | 64 | Base address (general register or stack pointer) |
| index | input | 64 | Element index, never modified |
| enc_match | output | 1 | Operation word recognised |
| undef | output | 1 | Recognised word with a faulting encoding |
| sp_base | output | 1 | Base register field selects the stack pointer |
| f_size | output | 2 | Size code field |
| f_rm | output | 5 | Index register field |
| f_pg | output | 3 | Predicate register field |
| f_rn | output | 5 | Base register field |
| f_zt | output | 5 | Data register field |
| sp_align_req | output | 1 | Stack-pointer alignment check request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 64 | Write byte address |
| wr_data | output | 16 | Write data |
| wr_bytes | output | 2 | Write size in bytes (always 2) |

## Verification
The assertions check the following on every cycle:
- the write port holds its address and data under back-pressure;
- the address steps by 2 per scanned position;
- `done` lasts one cycle and ends `busy`;
- no write is issued while idle;
- a faulting or mid-operation `start` leaves the block unchanged.

Only the bench scenarios can show that the emitted address and data sequence matches the reference loop. They run every size code under full, empty and scattered predicates, with an index that wraps the address past 2^64. They also show that the alignment request appears only when a stack-pointer base has no active lane.

// File: rtl/halfword_pred_store.sv
module halfword_pred_store #(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     instr,
  input  logic [VLEN-1:0] vec_data,
  input  logic [VLEN/8-1:0] pred,
  input  logic [63:0]     base,
  input  logic [63:0]     index,
  output logic            enc_match,
  output logic            undef,
  output logic            sp_base,
  output logic [1:0]      f_size,
  output logic [4:0]      f_rm,
  output logic [2:0]      f_pg,
  output logic [4:0]      f_rn,
  output logic [4:0]      f_zt,
  output logic            sp_align_req,
  output logic            busy,
  output logic            done,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [63:0]     wr_addr,
  output logic [15:0]     wr_data,
  output logic [1:0]      wr_bytes
);
  localparam int PW   = VLEN / 8;
  localparam int NMAX = VLEN / 16;
  localparam int IW   = $clog2(NMAX) + 1;
  localparam int DW   = $clog2(VLEN);

  assign f_size = instr[22:21];
  assign f_rm   = instr[20:16];
  assign f_pg   = instr[12:10];
  assign f_rn   = instr[9:5];
  assign f_zt   = instr[4:0];

  assign enc_match = (instr[31:25] == 7'b1110010) && (instr[24:23] == 2'b01) &&
                     (instr[15:13] == 3'b010);
  assign undef   = enc_match && ((f_size == 2'b00) || (f_rm == 5'b11111));
  assign sp_base = enc_match && (f_rn == 5'b11111);

  logic accept;
  assign accept = start && !busy && enc_match && !undef;

  logic any_act;
  always_comb begin
    any_act = 1'b0;
    for (int i = 0; i < PW; i++)
      if (((i & ((1 << f_size) - 1)) == 0) && pred[i]) any_act = 1'b1;
  end
  assign sp_align_req = accept && sp_base && !any_act;

  logic [1:0]      sz_q;
  logic [VLEN-1:0] vec_q;
  logic [PW-1:0]   pred_q;
  logic [63:0]     addr_q;
  logic [IW-1:0]   idx_q;

  logic [IW-1:0] ppos, last_idx;
  logic [DW-1:0] dpos;
  logic          elem_act, step, last;

  assign ppos     = idx_q << sz_q;
  assign elem_act = pred_q[ppos];
  assign dpos     = DW'(idx_q) << ({1'b0, sz_q} + 3'd3);
  assign last_idx = IW'(NMAX >> (sz_q - 2'd1)) - IW'(1);
  assign last     = (idx_q == last_idx);
  assign step     = busy && (!elem_act || wr_ready);

  assign wr_valid = busy && elem_act;
  assign wr_addr  = addr_q;
  assign wr_data  = 16'(vec_q >> dpos);
  assign wr_bytes = 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      sz_q   <= 2'd1;
      vec_q  <= '0;
      pred_q <= '0;
      addr_q <= '0;
      idx_q  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        sz_q   <= f_size;
        vec_q  <= vec_data;
        pred_q <= pred;
        addr_q <= base + (index << 1);
        idx_q  <= '0;
      end else if (step) begin
        addr_q <= addr_q + 64'd2;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R11
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step && !last |=> wr_addr == $past(wr_addr) + 64'd2); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid); // R12
  AST_UNDEF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && undef |=> !busy); // R2
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(sz_q) && $stable(vec_q) && $stable(pred_q)); // R10
endmodule

// File: tb/halfword_pred_store_tb.sv
module halfword_pred_store_tb;
  localparam int VL = 128;
  localparam int PW = VL / 8;

  logic clk = 0, rst_n = 0, start = 0, wr_ready = 1;
  logic [31:0] instr = '0;
  logic [VL-1:0] vec_data = '0;
  logic [PW-1:0] pred = '0;
  logic [63:0] base = '0, index = '0;
  logic enc_match, undef, sp_base, sp_align_req, busy, done, wr_valid;
  logic [1:0] f_size, wr_bytes;
  logic [4:0] f_rm, f_rn, f_zt;
  logic [2:0] f_pg;
  logic [63:0] wr_addr;
  logic [15:0] wr_data;

  halfword_pred_store #(.VLEN(VL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .vec_data(vec_data),
    .pred(pred), .base(base), .index(index), .enc_match(enc_match), .undef(undef),
    .sp_base(sp_base), .f_size(f_size), .f_rm(f_rm), .f_pg(f_pg), .f_rn(f_rn),
    .f_zt(f_zt), .sp_align_req(sp_align_req), .busy(busy), .done(done),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_bytes(wr_bytes));

  always #2 clk = ~clk;

  int errs = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic [4:0] rm,
                                     input logic [2:0] pg, input logic [4:0] rn,
                                     input logic [4:0] zt);
    return {7'b1110010, 2'b01, sz, rm, 3'b010, pg, rn, zt};
  endfunction

  localparam int NT = 10;
  localparam logic [1:0]  T_SZ [NT] = '{2'd1, 2'd2, 2'd3, 2'd1, 2'd2, 2'd3, 2'd1, 2'd2, 2'd3, 2'd1};
  localparam logic [15:0] T_PR [NT] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000, 16'hA5C3,
                                        16'h0101, 16'h5A3C, 16'h0000, 16'hFEFE, 16'h8001};
  localparam logic [63:0] T_IX [NT] = '{64'd0, 64'd5, 64'd3, 64'd1, 64'd7, 64'd2,
                                        64'hFFFF_FFFF_FFFF_FFFE, 64'd9, 64'd0, 64'd4};
  localparam logic [63:0] T_BS [NT] = '{64'h1000, 64'h2000, 64'h3000, 64'h4000, 64'h5000,
                                        64'h6000, 64'h10, 64'h7000, 64'h8000, 64'h9000};
  localparam logic [4:0]  T_RN [NT] = '{5'd3, 5'd4, 5'd5, 5'd3, 5'd6, 5'd7, 5'd8, 5'd31, 5'd31, 5'd31};
  localparam logic [1:0]  T_ST [NT] = '{2'd0, 2'd1, 2'd0, 2'd1, 2'd1, 2'd0, 2'd1, 2'd0, 2'd0, 2'd2};

  task automatic run_op(input int k, input logic [1:0] sz, input logic [15:0] pr,
                        input logic [63:0] ix, input logic [63:0] bs,
                        input logic [4:0] rn, input logic [1:0] st);
    logic [VL-1:0] v, tmp;
    logic [63:0] ea [8];
    logic [15:0] ed [8];
    logic [63:0] a, h_addr;
    logic [15:0] h_data;
    int es, nel, nexp, nw, stalls, cyc;
    bit any, held, seen;
    for (int b = 0; b < PW; b++) v[b*8 +: 8] = 8'(b * 29 + k * 7 + 3);
    es = 8 << sz; nel = VL / es; nexp = 0; any = 0;
    a = bs + ix * 2;
    for (int e = 0; e < nel; e++) begin
      if (pr[(e * es) / 8]) begin
        tmp = v >> (e * es);
        ea[nexp] = a; ed[nexp] = tmp[15:0]; nexp++; any = 1;
      end
      a = a + 2;
    end
    @(negedge clk);
    instr = mk(sz, 5'd4, 3'd1, rn, 5'd9);
    vec_data = v; pred = pr; base = bs; index = ix; start = 1; wr_ready = 0;
    #1;
    chk(sp_align_req == (rn == 5'd31 && !any), "R8", $sformatf("op%0d sp_align_req", k),
        64'(sp_align_req), 64'(rn == 5'd31 && !any));
    nw = 0; stalls = 0; cyc = 0; held = 0; seen = 0;
    while (cyc < 200) begin
      @(negedge clk);
      cyc++;
      start = 0;
      if (st == 2 && cyc == 2) begin
        start = 1; base = 64'hDEAD_0000; instr = mk(2'd1, 5'd4, 3'd1, 5'd2, 5'd9);
        pred = 16'hFFFF;
      end
      wr_ready = (st == 0) ? 1'b1 : (cyc % 3 != 1);
      #1;
      if (held)
        chk(wr_valid && wr_addr == h_addr && wr_data == h_data, "R11",
            $sformatf("op%0d hold addr", k), wr_addr, h_addr);
      held = 0;
      if (done) begin seen = 1; break; end
      if (wr_valid && !wr_ready) begin
        stalls++; held = 1; h_addr = wr_addr; h_data = wr_data;
      end
      if (wr_valid && wr_ready) begin
        if (nw < nexp) begin
          chk(wr_addr == ea[nw], nw == 0 ? "R3" : "R4", $sformatf("op%0d write %0d addr", k, nw),
              wr_addr, ea[nw]);
          chk(wr_data == ed[nw] && wr_bytes == 2'd2, "R6", $sformatf("op%0d write %0d data", k, nw),
              64'(wr_data), 64'(ed[nw]));
        end
        nw++;
      end
    end
    start = 0;
    chk(seen && !busy, "R9", $sformatf("op%0d done with busy low", k), 64'(busy), 64'd0);
    chk(nw == nexp, "R7", $sformatf("op%0d write count", k), 64'(nw), 64'(nexp));
    chk(cyc == nel + stalls + 1, "R5", $sformatf("op%0d scan cycles", k), 64'(cyc),
        64'(nel + stalls + 1));
    @(negedge clk); #1;
    chk(!done && !busy, st == 2 ? "R10" : "R9", $sformatf("op%0d after done", k),
        64'({done, busy}), 64'd0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++; errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !wr_valid, "R12", "reset state", 64'({busy, done, wr_valid}), 64'd0);
    @(negedge clk); rst_n = 1;

    instr = mk(2'b10, 5'd7, 3'd5, 5'd12, 5'd20); #1;
    chk(enc_match && !undef && f_size == 2'b10 && f_rm == 5'd7 && f_pg == 3'd5 &&
        f_rn == 5'd12 && f_zt == 5'd20, "R1", "field extract",
        64'({enc_match, undef, f_size, f_rm, f_pg, f_rn, f_zt}),
        64'({1'b1, 1'b0, 2'b10, 5'd7, 3'd5, 5'd12, 5'd20}));

    @(negedge clk); instr = mk(2'b01, 5'd1, 3'd0, 5'd2, 5'd3) ^ 32'h0000_4000;
    pred = '1; start = 1; #1;
    chk(!enc_match, "R1", "mismatch flagged", 64'(enc_match), 64'd0);
    @(negedge clk); start = 0; #1;
    chk(!busy, "R1", "mismatch not started", 64'(busy), 64'd0);

    @(negedge clk); instr = mk(2'b00, 5'd1, 3'd0, 5'd2, 5'd3); start = 1; #1;
    chk(undef, "R2", "size 00 undef", 64'(undef), 64'd1);
    @(negedge clk); start = 0; #1;
    chk(!busy, "R2", "size 00 not started", 64'(busy), 64'd0);

    @(negedge clk); instr = mk(2'b11, 5'd31, 3'd0, 5'd31, 5'd3); start = 1; #1;
    chk(undef && sp_base, "R2", "rm 11111 undef", 64'({undef, sp_base}), 64'd3);
    @(negedge clk); start = 0; #1;
    chk(!busy, "R2", "rm 11111 not started", 64'(busy), 64'd0);

    for (int k = 0; k < NT; k++)
      run_op(k, T_SZ[k], T_PR[k], T_IX[k], T_BS[k], T_RN[k], T_ST[k]);

    finish_run();
  end
endmodule